// File: doc/BRIEF.md
# Multichannel ADC Capture Packer

This block sits behind four ADC channels that share one sample clock and deliver a new signed sample on every edge. Each sample passes through its own gain-and-offset correction lane. The four corrected 16-bit values are packed into a 64-bit word, and sixteen consecutive words are gathered into one 1024-bit beat. The beat leaves on a valid/ready stream toward a wide memory writer.

A capture sequencer decides which words are kept. A start pulse arms it. It then keeps a programmed number of words, rounded up to whole beats, and parks in a done state until it is cleared. For checking the memory path, a test mode replaces the corrected samples with a free-running 64-bit count.

The sample inputs carry no handshake, because an ADC cannot be stalled. Back-pressure therefore works as follows:
- A beat offered on `m_data_o` is held, together with `m_valid_o`, until a cycle where `m_ready_i` is high.
- The next beat keeps filling while the sink is stalled, which gives sixteen cycles of slack.
- If a beat completes while the previous one is still unaccepted, the new beat is dropped and a sticky overflow flag is raised.

Top module: `adc_capture_packer`

## Requirements
- R1: Channel k's corrected value occupies bits [16k+15:16k] of the 64-bit word, so channel 0 is in the low bits and channel 3 is in bits [63:48]. Channel k's raw sample, gain and offset are taken from `samples_i[14k+13:14k]`, `gain_i[16k+15:16k]` and `offset_i[16k+15:16k]`.
- R2: The corrected value is floor(sample × gain / 2^14) + offset, clamped to the range -32768..32767. Sample, gain and offset are all two's complement. The value is ready two clocks after the sample is presented.
- R3: Gain and offset values that change while capture runs apply to the sample presented in the same clock as the new values.
- R4: A gain of zero with an offset of zero gives a corrected value of zero for every sample.
- R5: One beat holds sixteen consecutive kept words. The earliest word is in bits [63:0] and the latest is in bits [1023:960].
- R6: A start pulse seen in the idle state moves the sequencer to an armed state for one clock. Words are kept from the clock after that. `capturing_o` is high in exactly the clocks in which a word is kept.
- R7: The word count latched at start is rounded up to a multiple of 16. Exactly that many words are kept, so exactly count/16 beats are produced. A count of zero produces no beat and goes straight to done.
- R8: `done_o` is high after the last word is kept and stays high until a `clear_i` pulse returns the sequencer to idle. A start pulse outside the idle state is ignored, and so is the word count presented with it.
- R9: In test mode the kept words are a 64-bit count that advances by one every clock, so consecutive kept words differ by exactly one.
- R10: While `m_valid_o` is high and `m_ready_i` is low, `m_valid_o` and `m_data_o` hold their values on the next clock.
- R11: If a beat completes while the previous beat is still unaccepted, the new beat is discarded and `overflow_o` rises. `overflow_o` stays high until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samples_i | input | 56 | Four raw 14-bit samples, one per clock, channel 0 lowest |
| gain_i | input | 64 | Four signed 16-bit gains, where 16384 means unity |
| offset_i | input | 64 | Four signed 16-bit offsets |
| test_mode_i | input | 1 | Substitute the 64-bit count for the corrected samples |
| start_i | input | 1 | Arm a capture (used only when idle) |
| clear_i | input | 1 | Return from done to idle |
| word_count_i | input | 24 | Number of 64-bit words to keep, latched at start |
| capturing_o | output | 1 | A word is being kept this clock |
| done_o | output | 1 | Capture finished |
| overflow_o | output | 1 | A beat was dropped since the last start |
| m_data_o | output | 1024 | Output beat |
| m_valid_o | output | 1 | Output beat valid |
| m_ready_i | input | 1 | Sink accepts the beat |

## Verification
The bench goes after the following corner cases:
- **Clamp and shift.** Large positive and negative gain and offset pairs drive the clamp at both rails. A design that wraps instead of clamping, or that rounds the shift the wrong way, mismatches in single words.
- **Coefficient timing.** Coefficients are changed every clock. A lane that pairs a sample with coefficients from a neighbouring clock fails this.
- **Word count.** Counts of 20 and 0 check the rounding and the empty capture. A sequencer that truncates instead of rounding up, or that hangs on zero, delivers the wrong number of beats.
- **Ignored start and held done.** A start pulse in the middle of a capture, and a wait before clear, check that a re-armed sequencer does not produce extra beats and that done does not drop early.
- **Back-pressure.** Short stalls must lose nothing and keep data stable. A long stall must drop the later beats, keep the first one, and hold the overflow flag until the next start.
- **Test mode.** A count that skips or repeats shows up as a break in the sequence of kept words.

// File: rtl/cap_pkg.sv
package cap_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE    = 2'd0,
    SEQ_ARMED   = 2'd1,
    SEQ_CAPTURE = 2'd2,
    SEQ_DONE    = 2'd3
  } seq_state_e;

endpackage

// File: rtl/cal_lane.sv
module cal_lane #(
  parameter int SW   = 14,
  parameter int CW   = 16,
  parameter int OW   = 16,
  parameter int FRAC = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [SW-1:0] sample_i,
  input  logic signed [CW-1:0] gain_i,
  input  logic signed [OW-1:0] offset_i,
  output logic signed [OW-1:0] cal_o
);

  localparam int PW   = SW + CW;
  localparam int SHW  = PW - FRAC;
  localparam int SUMW = ((SHW > OW) ? SHW : OW) + 1;

  // Stage 1: product, with the offset carried alongside it.
  logic signed [PW-1:0] prod_q;
  logic signed [OW-1:0] off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
      off_q  <= '0;
    end else begin
      prod_q <= PW'(sample_i) * PW'(gain_i);
      off_q  <= offset_i;
    end
  end

  // Stage 2: scale, add the offset, clamp.
  logic signed [SHW-1:0]  scaled;
  logic signed [SUMW-1:0] sum;
  logic                   ovf_hi;
  logic                   ovf_lo;
  logic signed [OW-1:0]   sat;

  always_comb begin
    scaled = prod_q[PW-1:FRAC];
    sum    = SUMW'(scaled) + SUMW'(off_q);
    ovf_hi = !sum[SUMW-1] && (sum[SUMW-2:OW-1] != '0);
    ovf_lo =  sum[SUMW-1] && (sum[SUMW-2:OW-1] != '1);
    if (ovf_hi)      sat = {1'b0, {(OW-1){1'b1}}};
    else if (ovf_lo) sat = {1'b1, {(OW-1){1'b0}}};
    else             sat = sum[OW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cal_o <= '0;
    else        cal_o <= sat;
  end

  AST_ZERO_COEF: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_i == '0 && offset_i == '0) |-> ##2 (cal_o == '0)); // R4

  AST_CLAMP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_i == '0) |-> ##2 (cal_o == $past(offset_i, 2))); // R2

endmodule

// File: rtl/capture_seq.sv
module capture_seq
  import cap_pkg::*;
#(
  parameter int CNTW = 24,
  parameter int WPB  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            clear_i,
  input  logic [CNTW-1:0] word_count_i,
  output logic            take_o,
  output logic            done_o,
  output logic            restart_o
);

  localparam int TW = CNTW + 1;
  localparam logic [TW-1:0] RND  = TW'(WPB - 1);
  localparam logic [TW-1:0] MASK = ~RND;

  seq_state_e      state_q;
  logic [TW-1:0]   target_q;
  logic [TW-1:0]   wcnt_q;
  logic [TW-1:0]   rounded;

  assign rounded   = ({1'b0, word_count_i} + RND) & MASK;
  assign restart_o = (state_q == SEQ_IDLE) && start_i;
  assign take_o    = (state_q == SEQ_CAPTURE);
  assign done_o    = (state_q == SEQ_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SEQ_IDLE;
      target_q <= '0;
      wcnt_q   <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (start_i) begin
            target_q <= rounded;
            wcnt_q   <= '0;
            state_q  <= SEQ_ARMED;
          end
        end
        SEQ_ARMED: begin
          state_q <= (target_q == '0) ? SEQ_DONE : SEQ_CAPTURE;
        end
        SEQ_CAPTURE: begin
          wcnt_q <= wcnt_q + 1'b1;
          if (wcnt_q == target_q - 1'b1) state_q <= SEQ_DONE;
        end
        SEQ_DONE: begin
          if (clear_i) state_q <= SEQ_IDLE;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_IDLE && start_i) |=> (state_q == SEQ_ARMED)); // R6

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_CAPTURE) |-> (wcnt_q < target_q)); // R7

  AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_DONE && clear_i) |=> (state_q == SEQ_IDLE)); // R8

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_DONE && !clear_i) |=> (state_q == SEQ_DONE)); // R8

endmodule

// File: rtl/beat_gearbox.sv
module beat_gearbox #(
  parameter int WW  = 64,
  parameter int WPB = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart_i,
  input  logic              take_i,
  input  logic [WW-1:0]     word_i,
  output logic [WW*WPB-1:0] m_data_o,
  output logic              m_valid_o,
  input  logic              m_ready_i,
  output logic              overflow_o
);

  localparam int BW   = WW * WPB;
  localparam int LOGW = $clog2(WPB);

  logic [LOGW-1:0] fill_q;
  logic [BW-1:0]   beat_w;
  logic            last;
  logic            can_load;

  assign last     = take_i && (fill_q == LOGW'(WPB - 1));
  assign can_load = !m_valid_o || m_ready_i;

  for (genvar i = 0; i < WPB; i++) begin : g_slot
    if (i < WPB - 1) begin : g_reg
      logic [WW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                q <= '0;
        else if (take_i && fill_q == LOGW'(i))     q <= word_i;
      end
      assign beat_w[i*WW +: WW] = q;
    end else begin : g_tail
      assign beat_w[i*WW +: WW] = word_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q     <= '0;
      m_valid_o  <= 1'b0;
      m_data_o   <= '0;
      overflow_o <= 1'b0;
    end else begin
      if (restart_i)   fill_q <= '0;
      else if (take_i) fill_q <= fill_q + 1'b1;

      if (last && can_load) begin
        m_data_o  <= beat_w;
        m_valid_o <= 1'b1;
      end else if (m_valid_o && m_ready_i) begin
        m_valid_o <= 1'b0;
      end

      if (restart_i)                overflow_o <= 1'b0;
      else if (last && !can_load)   overflow_o <= 1'b1;
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid_o && !m_ready_i) |=> (m_valid_o && $stable(m_data_o))); // R10

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow_o && !restart_i) |=> overflow_o); // R11

  AST_DROP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (last && m_valid_o && !m_ready_i) |=> (overflow_o && $stable(m_data_o))); // R11

endmodule

// File: rtl/adc_capture_packer.sv
module adc_capture_packer #(
  parameter int NCH  = 4,
  parameter int SW   = 14,
  parameter int CW   = 16,
  parameter int OW   = 16,
  parameter int FRAC = 14,
  parameter int WPB  = 16,
  parameter int CNTW = 24
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NCH*SW-1:0]         samples_i,
  input  logic [NCH*CW-1:0]         gain_i,
  input  logic [NCH*OW-1:0]         offset_i,
  input  logic                      test_mode_i,
  input  logic                      start_i,
  input  logic                      clear_i,
  input  logic [CNTW-1:0]           word_count_i,
  output logic                      capturing_o,
  output logic                      done_o,
  output logic                      overflow_o,
  output logic [NCH*OW*WPB-1:0]     m_data_o,
  output logic                      m_valid_o,
  input  logic                      m_ready_i
);

  localparam int WW = NCH * OW;

  logic [WW-1:0] cal_w;
  logic [WW-1:0] pattern_q;
  logic [WW-1:0] word_w;
  logic          take;
  logic          restart;

  for (genvar k = 0; k < NCH; k++) begin : g_lane
    logic signed [OW-1:0] lane_out;
    cal_lane #(.SW(SW), .CW(CW), .OW(OW), .FRAC(FRAC)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .sample_i (samples_i[k*SW +: SW]),
      .gain_i   (gain_i[k*CW +: CW]),
      .offset_i (offset_i[k*OW +: OW]),
      .cal_o    (lane_out)
    );
    assign cal_w[k*OW +: OW] = lane_out;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pattern_q <= '0;
    else        pattern_q <= pattern_q + 1'b1;
  end

  assign word_w = test_mode_i ? pattern_q : cal_w;

  capture_seq #(.CNTW(CNTW), .WPB(WPB)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .clear_i      (clear_i),
    .word_count_i (word_count_i),
    .take_o       (take),
    .done_o       (done_o),
    .restart_o    (restart)
  );

  beat_gearbox #(.WW(WW), .WPB(WPB)) u_gear (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart_i  (restart),
    .take_i     (take),
    .word_i     (word_w),
    .m_data_o   (m_data_o),
    .m_valid_o  (m_valid_o),
    .m_ready_i  (m_ready_i),
    .overflow_o (overflow_o)
  );

  assign capturing_o = take;

  AST_PATTERN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (take && test_mode_i) |=> (pattern_q == $past(word_w) + 1'b1)); // R9

endmodule

// File: tb/adc_capture_packer_tb.sv
module adc_capture_packer_tb;

  localparam int PERIOD = 10;
  localparam int NCH = 4;
  localparam int WPB = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [55:0]     samples_i = '0;
  logic [63:0]     gain_i = '0;
  logic [63:0]     offset_i = '0;
  logic            test_mode_i = 1'b0;
  logic            start_i = 1'b0;
  logic            clear_i = 1'b0;
  logic [23:0]     word_count_i = '0;
  logic            capturing_o;
  logic            done_o;
  logic            overflow_o;
  logic [1023:0]   m_data_o;
  logic            m_valid_o;
  logic            m_ready_i = 1'b1;

  always #(PERIOD/2) clk = ~clk;

  adc_capture_packer u_dut (
    .clk(clk), .rst_n(rst_n), .samples_i(samples_i), .gain_i(gain_i),
    .offset_i(offset_i), .test_mode_i(test_mode_i), .start_i(start_i),
    .clear_i(clear_i), .word_count_i(word_count_i), .capturing_o(capturing_o),
    .done_o(done_o), .overflow_o(overflow_o), .m_data_o(m_data_o),
    .m_valid_o(m_valid_o), .m_ready_i(m_ready_i)
  );

  int checks = 0;
  int fails  = 0;
  int beats_rx = 0;
  int cyc = 0;
  bit sb_on = 0;
  bit r4_watch = 0;
  bit tmode_chk = 0;
  bit have_last = 0;
  bit coef_rand = 0;
  bit bp_mode = 0;
  logic [63:0] last_word;
  logic [63:0] exp_q[$];
  logic [63:0] exp_d1 = '0, exp_d2 = '0;
  int s[4], g[4], o[4];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic logic [15:0] cal(input int sv, input int gv, input int ov);
    longint p;
    p = longint'(sv) * longint'(gv);
    p = p >>> 14;
    p = p + longint'(ov);
    if (p > 32767) p = 32767;
    if (p < -32768) p = -32768;
    return p[15:0];
  endfunction

  function automatic logic [63:0] exp_word();
    logic [63:0] w;
    for (int k = 0; k < NCH; k++) w[k*16 +: 16] = cal(s[k], g[k], o[k]);
    return w;
  endfunction

  // Driver: one clock per call, inputs change at the falling edge.
  task automatic step();
    @(negedge clk);
    cyc++;
    if (sb_on && capturing_o) exp_q.push_back(exp_d2);
    exp_d2 = exp_d1;
    for (int k = 0; k < NCH; k++) begin
      s[k] = int'($urandom_range(16383, 0)) - 8192;
      if (coef_rand) begin
        g[k] = int'($urandom_range(65535, 0)) - 32768;
        o[k] = int'($urandom_range(65535, 0)) - 32768;
      end
    end
    exp_d1 = exp_word();
    for (int k = 0; k < NCH; k++) begin
      samples_i[k*14 +: 14] = s[k][13:0];
      gain_i[k*16 +: 16]    = g[k][15:0];
      offset_i[k*16 +: 16]  = o[k][15:0];
    end
    if (bp_mode) m_ready_i = ((cyc / 5) % 2) == 0;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done_o && n < 3000) begin step(); n++; end
    chk(done_o == 1'b1, req, "done reached", done_o, 1);
  endtask

  task automatic pulse_start(input int wc);
    word_count_i = 24'(wc);
    start_i = 1'b1;
    step();
    start_i = 1'b0;
  endtask

  task automatic do_clear();
    clear_i = 1'b1;
    step();
    clear_i = 1'b0;
  endtask

  // Monitor: pops expected words and compares each accepted beat.
  logic [1023:0] held;
  bit stall_prev = 0;
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (stall_prev) begin
        chk(m_valid_o == 1'b1 && m_data_o == held, "R10", "beat held under stall",
            longint'(m_data_o[63:0]), longint'(held[63:0]));
      end
      stall_prev = m_valid_o && !m_ready_i;
      held = m_data_o;
      if (m_valid_o && m_ready_i) begin
        beats_rx++;
        if (sb_on) begin
          bit ok = 1;
          logic [63:0] ew, aw;
          ew = '0; aw = '0;
          for (int i = 0; i < WPB; i++) begin
            logic [63:0] e;
            e = (exp_q.size() > 0) ? exp_q.pop_front() : ~m_data_o[i*64 +: 64];
            if (ok && e != m_data_o[i*64 +: 64]) begin
              ok = 0; ew = e; aw = m_data_o[i*64 +: 64];
            end
          end
          chk(ok, "R1/R2/R5", "beat word", longint'(aw), longint'(ew));
        end
        if (r4_watch) begin
          bit z = 1;
          for (int i = 0; i < WPB; i++) if (m_data_o[i*64+48 +: 16] != 16'h0) z = 0;
          chk(z, "R4", "zero-gain channel all zero", z, 1);
        end
        if (tmode_chk) begin
          bit ok2 = 1;
          for (int i = 0; i < WPB; i++) begin
            if (have_last && m_data_o[i*64 +: 64] != last_word + 64'd1) ok2 = 0;
            last_word = m_data_o[i*64 +: 64];
            have_last = 1;
          end
          chk(ok2, "R9", "counter words consecutive", longint'(last_word), 0);
        end
      end
    end
  end

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int b0;
    for (int k = 0; k < NCH; k++) begin s[k] = 0; g[k] = 0; o[k] = 0; end
    steps(4);
    rst_n = 1'b1;
    step();
    chk(m_valid_o == 1'b0, "R10", "reset valid", m_valid_o, 0);
    chk(done_o == 1'b0, "R8", "reset done", done_o, 0);
    chk(overflow_o == 1'b0, "R11", "reset overflow", overflow_o, 0);
    chk(capturing_o == 1'b0, "R6", "reset capturing", capturing_o, 0);

    // T1: plain gains, ignored start mid-capture, done hold and clear
    g = '{16384, 8192, -16384, 0};
    o = '{0, 100, -50, 0};
    sb_on = 1; r4_watch = 1; exp_q.delete();
    steps(3);
    b0 = beats_rx;
    pulse_start(32);
    chk(capturing_o == 1'b0, "R6", "armed clock keeps nothing", capturing_o, 0);
    step();
    chk(capturing_o == 1'b1, "R6", "capture begins after armed", capturing_o, 1);
    steps(8);
    pulse_start(500);
    wait_done("R7");
    steps(4);
    chk(beats_rx - b0 == 2, "R8", "late start ignored, beats", beats_rx - b0, 2);
    steps(5);
    chk(done_o == 1'b1, "R8", "done held", done_o, 1);
    do_clear();
    chk(done_o == 1'b0, "R8", "clear returns idle", done_o, 0);
    r4_watch = 0;

    // T2: saturation at both rails, count rounding
    g = '{16384, 32767, -32768, 16384};
    o = '{0, 25000, -25000, 32767};
    steps(3);
    b0 = beats_rx;
    pulse_start(20);
    wait_done("R7");
    steps(4);
    chk(beats_rx - b0 == 2, "R7", "count 20 rounds to 2 beats", beats_rx - b0, 2);
    do_clear();

    // T3: coefficients changing every clock
    coef_rand = 1;
    steps(3);
    b0 = beats_rx;
    pulse_start(64);
    wait_done("R3");
    steps(4);
    chk(beats_rx - b0 == 4, "R3", "beats with changing coefs", beats_rx - b0, 4);
    do_clear();
    coef_rand = 0;

    // T4: zero count
    b0 = beats_rx;
    pulse_start(0);
    steps(3);
    chk(done_o == 1'b1, "R7", "zero count done", done_o, 1);
    steps(3);
    chk(beats_rx - b0 == 0, "R7", "zero count no beats", beats_rx - b0, 0);
    do_clear();

    // T6: test pattern
    sb_on = 0; tmode_chk = 1; have_last = 0; test_mode_i = 1'b1;
    steps(2);
    b0 = beats_rx;
    pulse_start(48);
    wait_done("R9");
    steps(4);
    chk(beats_rx - b0 == 3, "R9", "test mode beats", beats_rx - b0, 3);
    do_clear();
    tmode_chk = 0; test_mode_i = 1'b0;

    // T7: short stalls lose nothing
    g = '{12000, -7000, 20000, 16384};
    o = '{5, -5, 300, -300};
    sb_on = 1; exp_q.delete();
    steps(3);
    bp_mode = 1;
    b0 = beats_rx;
    pulse_start(64);
    wait_done("R10");
    steps(12);
    bp_mode = 0; m_ready_i = 1'b1;
    steps(4);
    chk(beats_rx - b0 == 4, "R10", "beats under short stalls", beats_rx - b0, 4);
    chk(overflow_o == 1'b0, "R11", "no overflow under short stalls", overflow_o, 0);
    do_clear();

    // T8: long stall drops later beats
    sb_on = 0;
    m_ready_i = 1'b0;
    steps(2);
    b0 = beats_rx;
    pulse_start(48);
    wait_done("R11");
    steps(3);
    chk(overflow_o == 1'b1, "R11", "overflow raised", overflow_o, 1);
    chk(m_valid_o == 1'b1, "R11", "first beat still pending", m_valid_o, 1);
    m_ready_i = 1'b1;
    steps(6);
    chk(beats_rx - b0 == 1, "R11", "only first beat delivered", beats_rx - b0, 1);
    chk(overflow_o == 1'b1, "R11", "overflow sticky", overflow_o, 1);
    do_clear();
    pulse_start(0);
    chk(overflow_o == 1'b0, "R11", "start clears overflow", overflow_o, 0);
    steps(3);
    do_clear();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule